// File: doc/BRIEF.md
# Fused Add-Multiply Operator

This block computes the signed product Z = X·(A+B). It has no adder in front of the multiplier. Instead, the two addends A and B are turned directly into radix-4 signed digits. Each digit lies in {-2, -1, 0, +1, +2}. A chain of small per-pair cells does the conversion. Each cell looks at two bit positions of A and B, plus two carries from the cell below it. The carries do not ripple further than one cell, so the recoder has a fixed depth whatever the width.

Each digit selects one partial product: 0, ±X or ±2X. The rows are shifted by two bit positions per digit and reduced in carry-save form. One carry-propagate adder at the end produces Z.

The operand width N is an even parameter. The sum A+B needs N+1 bits, so the recoder produces N/2+1 digits. The top digit only ever takes the values -1, 0 or +1. The result is 2N+2 bits wide, which holds every product X·(A+B) with room to spare. The parameter OUT_REG selects the output timing. With OUT_REG=1 the result goes through a single output register with asynchronous reset. With OUT_REG=0 the result appears combinationally.

Top module: `fam_operator`

## Requirements
- R1: With operands X, A, B read as N-bit two's complement, z_o read as a 2N+2-bit two's complement number equals X·(A+B) exactly, for every input combination.
- R2: Each recoded digit is encoded as three flags: negative, magnitude one and magnitude two. Magnitude one and magnitude two are never set together, and the negative flag is never set on a zero digit. A digit of ±2 doubles X correctly, including the most negative X. For example, when A+B = ±2·4^j the result is X·(±2·4^j).
- R3: The digits, each weighted by 4^j for digit index j = 0 .. N/2, add up exactly to A+B. With X = 1, z_o equals A+B sign-extended to 2N+2 bits.
- R4: The extra top digit, at index N/2, lies in {-1, 0, +1}. The result is still exact when both addends sit at the most negative or the most positive N-bit value.
- R5: With OUT_REG=1, z_o shows the result for the inputs present at the previous rising edge of clk_i, and holds that value until the next rising edge. With OUT_REG=0, z_o follows the inputs without a clock edge.
- R6: With OUT_REG=1, a low level on rst_ni forces z_o to 0 at once, without waiting for a clock edge, and holds it at 0 while rst_ni stays low.
- R7: No stray sign-correction term survives. X = 0 gives z_o = 0 for every A and B, and A+B = 0 gives z_o = 0 for every X.
- R8: The result is exact at the extremes of the range. For example, X = A = B = -2^(N-1) gives 2^(2N-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| x_i | input | N | Multiplicand X, two's complement |
| a_i | input | N | First addend A, two's complement |
| b_i | input | N | Second addend B, two's complement |
| z_o | output | 2N+2 | Product X·(A+B), two's complement |

## Verification
The registered instance has its result due one rising edge after the inputs are applied. The bench changes the inputs on a falling edge and reads the result on the following falling edge. It also checks 1 ns after each change that z_o still shows the previous result. The combinational instance has no clock in its path, so it is read 1 ns after each change of its inputs. The reset check lowers rst_ni away from any clock edge and reads z_o 1 ns later.

// File: rtl/fam_pkg.sv
package fam_pkg;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } bdigit_t;

  // encode a small signed value in [-2,2] as sign/magnitude flags
  function automatic bdigit_t enc_digit(input logic signed [3:0] v);
    bdigit_t d;
    logic [3:0] m;
    m     = (v < 0) ? 4'(-v) : 4'(v);
    d.neg = (v < 0);
    d.one = (m == 4'd1);
    d.two = (m == 4'd2);
    return d;
  endfunction

endpackage

// File: rtl/fam_sum_recoder.sv
module fam_sum_recoder
  import fam_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]              a_i,
  input  logic [N-1:0]              b_i,
  output bdigit_t [N/2:0]           dig_o
);
  localparam int K = N / 2;

  logic [K:0] cin1;  // carry of upper half adder from cell below
  logic [K:0] cin2;  // carry of signed half adder from cell below

  assign cin1[0] = 1'b0;
  assign cin2[0] = 1'b0;

  for (genvar j = 0; j < K - 1; j++) begin : g_cell
    logic hu, cu, s0, cf, s1;
    assign hu = a_i[2*j+1] ^ b_i[2*j+1];
    assign cu = a_i[2*j+1] & b_i[2*j+1];
    assign s0 = a_i[2*j] ^ b_i[2*j] ^ cin1[j];
    assign cf = (a_i[2*j] & b_i[2*j]) | (cin1[j] & (a_i[2*j] | b_i[2*j]));
    // hu + cf = 2*c - s1, with s1 negatively weighted
    assign s1 = hu ^ cf;
    assign cin1[j+1] = cu;
    assign cin2[j+1] = hu | cf;
    // digit = -2*s1 + s0 + cin2
    assign dig_o[j].one = s0 ^ cin2[j];
    assign dig_o[j].two = (s1 & ~s0 & ~cin2[j]) | (~s1 & s0 & cin2[j]);
    assign dig_o[j].neg = s1 & ~(s0 & cin2[j]);
  end

  // top cell: sign bits carry negative weight, value range [-4,4]
  logic signed [3:0] t_top, d_lo, d_hi;

  always_comb begin
    t_top = $signed({3'b000, a_i[N-2]}) + $signed({3'b000, b_i[N-2]})
          + $signed({3'b000, cin1[K-1]}) + $signed({3'b000, cin2[K-1]})
          - $signed({2'b00, a_i[N-1], 1'b0}) - $signed({2'b00, b_i[N-1], 1'b0});
    if (t_top > 4'sd2) begin
      d_lo = t_top - 4'sd4;
      d_hi = 4'sd1;
    end else if (t_top < -4'sd2) begin
      d_lo = t_top + 4'sd4;
      d_hi = -4'sd1;
    end else begin
      d_lo = t_top;
      d_hi = 4'sd0;
    end
  end

  assign dig_o[K-1] = enc_digit(d_lo);
  assign dig_o[K]   = enc_digit(d_hi);

endmodule

// File: rtl/fam_pp_row.sv
module fam_pp_row
  import fam_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] x_i,
  input  bdigit_t      dig_i,
  output logic [N:0]   row_o
);
  // xe[i+1] = x_i, xe[0] = x_{-1} = 0, xe[N+1] = sign extension
  logic [N+1:0] xe;
  assign xe = {x_i[N-1], x_i, 1'b0};

  for (genvar i = 0; i <= N; i++) begin : g_bit
    assign row_o[i] = ((xe[i+1] ^ dig_i.neg) & dig_i.one)
                    | ((xe[i]   ^ dig_i.neg) & dig_i.two);
  end

endmodule

// File: rtl/fam_csa_sum.sv
module fam_csa_sum #(
  parameter int W = 18,
  parameter int R = 7
) (
  input  logic [R-1:0][W-1:0] ops_i,
  output logic [W-1:0]        sum_o
);
  logic [W-1:0] ps [R-1];
  logic [W-1:0] pc [R-1];

  assign ps[0] = ops_i[0];
  assign pc[0] = ops_i[1];

  for (genvar r = 2; r < R; r++) begin : g_csa
    assign ps[r-1] = ps[r-2] ^ pc[r-2] ^ ops_i[r];
    assign pc[r-1] = ((ps[r-2] & pc[r-2]) | (ps[r-2] & ops_i[r])
                    | (pc[r-2] & ops_i[r])) << 1;
  end

  // single carry-propagate adder
  assign sum_o = ps[R-2] + pc[R-2];

endmodule

// File: rtl/fam_operator.sv
module fam_operator
  import fam_pkg::*;
#(
  parameter int N       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      x_i,
  input  logic [N-1:0]      a_i,
  input  logic [N-1:0]      b_i,
  output logic [2*N+1:0]    z_o
);
  localparam int W  = 2 * N + 2;
  localparam int K  = N / 2;
  localparam int ND = K + 1;
  localparam int R  = ND + 2;

  // removes the +2^N bias of each row's inverted top bit
  function automatic logic [W-1:0] corr_f();
    logic [W-1:0] c;
    c = '0;
    for (int j = 0; j < ND; j++) c = c - (W'(1) << (N + 2 * j));
    return c;
  endfunction
  localparam logic [W-1:0] CORR = corr_f();

  bdigit_t [ND-1:0]    dig;
  logic [N:0]          row [ND];
  logic [W-1:0]        sgn;
  logic [R-1:0][W-1:0] ops;
  logic [W-1:0]        prod;

  fam_sum_recoder #(.N(N)) u_rec (
    .a_i   (a_i),
    .b_i   (b_i),
    .dig_o (dig)
  );

  for (genvar j = 0; j < ND; j++) begin : g_row
    fam_pp_row #(.N(N)) u_pp (
      .x_i   (x_i),
      .dig_i (dig[j]),
      .row_o (row[j])
    );
    assign ops[j] = W'({~row[j][N], row[j][N-1:0]}) << (2 * j);
  end

  always_comb begin
    sgn = '0;
    for (int j = 0; j < ND; j++) sgn[2*j] = dig[j].neg;
  end

  assign ops[ND]   = sgn;
  assign ops[ND+1] = CORR;

  fam_csa_sum #(.W(W), .R(R)) u_sum (
    .ops_i (ops),
    .sum_o (prod)
  );

  if (OUT_REG) begin : g_reg
    logic [W-1:0] z_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) z_q <= '0;
      else         z_q <= prod;
    end
    assign z_o = z_q;
  end else begin : g_comb
    assign z_o = prod;
  end

  // ---------------- assertions ----------------
  logic signed [W-1:0] ab_ext, ref_w;
  logic [W-1:0]        rec_val;
  logic                armed;

  always_comb begin
    ab_ext = $signed({{(W-N){a_i[N-1]}}, a_i}) + $signed({{(W-N){b_i[N-1]}}, b_i});
    ref_w  = $signed({{(W-N){x_i[N-1]}}, x_i}) * ab_ext;
    rec_val = '0;
    for (int j = 0; j < ND; j++) begin
      if (dig[j].neg) rec_val = rec_val - (W'({dig[j].two, dig[j].one}) << (2 * j));
      else            rec_val = rec_val + (W'({dig[j].two, dig[j].one}) << (2 * j));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  for (genvar j = 0; j < ND; j++) begin : g_dchk
    // R2
    digit_enc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({dig[j].one, dig[j].two}) && (!dig[j].neg || dig[j].one || dig[j].two));
  end

  // R3
  recode_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_val == ab_ext);

  // R4
  top_digit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dig[ND-1].two);

  if (OUT_REG) begin : g_pchk
    // R1
    product_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed |-> (z_o == $past(ref_w)));
  end else begin : g_cchk
    // R1
    product_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      z_o == ref_w);
  end

endmodule

// File: tb/tb_fam_operator.sv
`timescale 1ns/1ps
module tb_fam_operator;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // narrow, registered instance
  logic [3:0]  xs, as_, bs;
  logic [9:0]  zs;
  // wide, combinational instance
  logic [7:0]  xw, aw, bw;
  logic [17:0] zw;

  fam_operator #(.N(4), .OUT_REG(1'b1)) dut (
    .clk_i (clk), .rst_ni (rst_n),
    .x_i (xs), .a_i (as_), .b_i (bs), .z_o (zs)
  );

  fam_operator #(.N(8), .OUT_REG(1'b0)) dut_wide (
    .clk_i (clk), .rst_ni (rst_n),
    .x_i (xw), .a_i (aw), .b_i (bw), .z_o (zw)
  );

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic string tag_of(input longint x, input longint a,
                                   input longint b, input longint lo);
    if (x == lo && a == lo && b == lo) return "R8";
    if (a == b && (a == lo || a == -lo - 1)) return "R4";
    if (x == 0 || a + b == 0) return "R7";
    if (x == 1) return "R3";
    return "R1";
  endfunction

  task automatic drive_wide(input longint x, input longint a, input longint b,
                            input string tag);
    @(negedge clk);
    xw = 8'(x); aw = 8'(a); bw = 8'(b);
    #1;
    chk(tag, longint'($signed(zw)), x * (a + b));
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint prev;
    xs = 4'd5; as_ = 4'd3; bs = 4'd2;
    xw = '0; aw = '0; bw = '0;
    repeat (3) @(negedge clk);
    chk("R6 reset", longint'($signed(zs)), 0);

    xs = '0; as_ = '0; bs = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 after release", longint'($signed(zs)), 0);
    prev = 0;

    // exhaustive sweep, registered instance
    for (int x = -8; x < 8; x++) begin
      for (int a = -8; a < 8; a++) begin
        for (int b = -8; b < 8; b++) begin
          @(negedge clk);
          xs = 4'(x); as_ = 4'(a); bs = 4'(b);
          #1;
          chk("R5 hold", longint'($signed(zs)), prev);
          @(negedge clk);
          prev = longint'(x) * longint'(a + b);
          chk(tag_of(x, a, b, -8), longint'($signed(zs)), prev);
        end
      end
    end

    // wide instance: extremes
    begin
      longint ev[5] = '{-128, 127, 0, 1, -1};
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int k = 0; k < 5; k++)
            drive_wide(ev[i], ev[j], ev[k], tag_of(ev[i], ev[j], ev[k], -128));
    end

    // R2: a single digit of +-2 at every position
    for (int j = 0; j < 4; j++) begin
      longint h = longint'(1) << (2 * j);
      drive_wide(-128, h, h, "R2");
      drive_wide(-128, -h, -h, "R2");
      drive_wide(85, h, h, "R2");
      drive_wide(127, -h, -h, "R2");
    end

    // R3: X = 1 passes the sum through
    for (int i = 0; i < 300; i++)
      drive_wide(1, longint'($signed(8'($urandom))), longint'($signed(8'($urandom))), "R3");

    // R5: combinational instance follows inputs
    for (int i = 0; i < 2500; i++)
      drive_wide(longint'($signed(8'($urandom))), longint'($signed(8'($urandom))),
                 longint'($signed(8'($urandom))), "R5 comb R1");

    // R6: asynchronous reset away from a clock edge
    @(negedge clk);
    xs = 4'd7; as_ = 4'd7; bs = 4'd7;
    @(posedge clk);
    #2;
    chk("R1 pre-reset", longint'($signed(zs)), 98);
    rst_n = 1'b0;
    #1;
    chk("R6 async", longint'($signed(zs)), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule